// File: doc/BRIEF.md
# Vector-Prefix Compliance Trap Checker

This decode-stage block decides, for every decoded instruction, whether a vector-prefixed instruction can run on the hardware or has to raise an illegal-instruction trap. Which features the hardware has is set by a build-time compliance level. An instruction without the prefix always runs and never traps here, so the base scalar ISA is never changed. A prefixed instruction that asks for anything the configured level lacks always traps.

A neighbouring decoder supplies a valid strobe and the decoded fields:
- the prefix flag and the 24-bit mode field;
- the current VL and MAXVL;
- the element-width overrides;
- the predicate source;
- Rc and the last CR field that vector co-results would reach;
- the remap kind;
- one nonzero flag per vector state register.

The decision is registered. When a trap is raised, the block saves the PC, the MSR and the live vector state word into shadow save registers. A return-from-trap strobe later presents the saved vector state word for restoring into the live register.

Levels are coded in 3 bits: 0 none, 1 ultra-embedded, 2 embedded, 3 embedded DSP, 4 high-end DSP, 5 advanced. A value above 5 behaves as 5.

Top module: `vpfx_trap_chk`

## Requirements
- R1: An instruction with the prefix flag low gives exec_o=1 and trap_o=0, whatever its other fields hold, at every level.
- R2: At level 0, every valid prefixed instruction traps.
- R3: A prefixed instruction is scalar identity when all of the following hold: the mode field is zero, every vector-state nonzero flag is zero, VL is 1 or less, and MAXVL is 1 or less. At any level of 1 or more it executes, whatever its other fields hold.
- R4: At level 1, every prefixed instruction that is not scalar identity traps.
- R5: At level 2 and above, a prefixed instruction with VL and MAXVL above 1 executes when no feature rule below is broken.
- R6: An element-width override traps below level 3. An override is present when either 2-bit field (source or destination) is nonzero; 0 means the default width.
- R7: Integer predication traps unless the mask source is GPR 3, 10 or 30. CR-field predication traps below level 3. The zeroing flags sz and dz never cause a trap.
- R8: With Rc=1, a last co-result CR field index of 8 or more traps below level 3. An index of 7 or less is accepted.
- R9: The 2-bit remap kind is coded 0 none, 1 offset/index, 2 matrix/DCT/FFT, 3 reserved. Kind 1 traps below level 4, kind 2 traps below level 5, and kind 3 always traps.
- R10: exec_o, trap_o and trap_vec_o are registered and valid one cycle after valid_i. They are all zero after a cycle without valid_i. exec_o and trap_o are never high together. trap_vec_o is 0x700 during a trap and 0 otherwise. Any number of violations at once gives a single trap.
- R11: The cycle after a trap decode, srr_pc_o, srr_msr_o and srr_vs_o hold the PC, the MSR and the vector state word of the trapped instruction. They keep those values until the next trap, and reset clears them to zero.
- R12: One cycle after rfi_i, vs_restore_o is high for that cycle and vs_restore_val_o equals the saved vector state word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Decoded instruction valid |
| pfx_i | input | 1 | Instruction carries the vector prefix |
| mode_i | input | 24 | Prefix remap/mode field |
| vl_i | input | VL_W | Current vector length |
| maxvl_i | input | VL_W | Current maximum vector length |
| ew_src_i | input | 2 | Source element-width override, 0 = default |
| ew_dst_i | input | 2 | Destination element-width override, 0 = default |
| pred_en_i | input | 1 | Predication requested |
| pred_cr_i | input | 1 | Predicate taken from a CR field (else a GPR) |
| pred_gpr_i | input | GPR_W | GPR number of the integer predicate |
| pred_sz_i | input | 1 | Source zeroing flag |
| pred_dz_i | input | 1 | Destination zeroing flag |
| rc_i | input | 1 | Rc bit |
| cr_last_i | input | CR_W | Last CR field reached by vector co-results |
| remap_i | input | 2 | Remap kind |
| vs_nz_i | input | NVS | Nonzero flag of each vector state register |
| pc_i | input | PC_W | PC of the instruction |
| msr_i | input | MSR_W | Current MSR |
| vstate_i | input | VS_W | Live vector state word |
| rfi_i | input | 1 | Return-from-trap strobe |
| exec_o | output | 1 | Execute in hardware |
| trap_o | output | 1 | Illegal-instruction trap |
| trap_vec_o | output | 12 | Trap vector |
| srr_pc_o | output | PC_W | Saved PC |
| srr_msr_o | output | MSR_W | Saved MSR |
| srr_vs_o | output | VS_W | Saved vector state word |
| vs_restore_o | output | 1 | Restore the live vector state this cycle |
| vs_restore_val_o | output | VS_W | Value to restore |

## Verification
The execute, trap and vector results, and the three save registers, change on the rising edge where valid_i is sampled. They are therefore due one cycle after the stimulus, and vs_restore_o is due one cycle after rfi_i. The bench drives each stimulus on a falling edge for one cycle and checks on the next falling edge, which is the first point where the registered outputs can hold the new value. Six instances, one per level, see the same stimulus, so each case is checked against a per-level expected trap mask in one pass. The hold checks sample the save registers again after a later non-trapping instruction and after the restore pulse.

// File: rtl/vpfx_pkg.sv
package vpfx_pkg;
  localparam logic [11:0] TRAP_VEC = 12'h700;

  typedef enum logic [2:0] {
    LVL_NONE  = 3'd0,
    LVL_ULTRA = 3'd1,
    LVL_EMB   = 3'd2,
    LVL_DSP   = 3'd3,
    LVL_HDSP  = 3'd4,
    LVL_ADV   = 3'd5
  } lvl_e;

  typedef enum logic [1:0] {
    RMP_NONE = 2'd0,
    RMP_IDX  = 2'd1,
    RMP_MTX  = 2'd2,
    RMP_RSVD = 2'd3
  } remap_e;
endpackage

// File: rtl/vpfx_ident.sv
module vpfx_ident #(
  parameter int unsigned VL_W = 7,
  parameter int unsigned NVS  = 4
) (
  input  logic [23:0]     mode_i,
  input  logic [VL_W-1:0] vl_i,
  input  logic [VL_W-1:0] maxvl_i,
  input  logic [NVS-1:0]  vs_nz_i,
  output logic            ident_o
);
  assign ident_o = (mode_i == 24'd0) && (vs_nz_i == '0) &&
                   (vl_i <= VL_W'(1)) && (maxvl_i <= VL_W'(1));
endmodule

// File: rtl/vpfx_rules.sv
module vpfx_rules
  import vpfx_pkg::*;
#(
  parameter logic [2:0]  LEVEL = 3'd5,
  parameter int unsigned CR_W  = 7,
  parameter int unsigned GPR_W = 5
) (
  input  logic             ident_i,
  input  logic [1:0]       ew_src_i,
  input  logic [1:0]       ew_dst_i,
  input  logic             pred_en_i,
  input  logic             pred_cr_i,
  input  logic [GPR_W-1:0] pred_gpr_i,
  input  logic             rc_i,
  input  logic [CR_W-1:0]  cr_last_i,
  input  logic [1:0]       remap_i,
  output logic             need_trap_o
);
  if (LEVEL == LVL_NONE) begin : g_none
    logic unused_flds;
    assign unused_flds = ^{ident_i, ew_src_i, ew_dst_i, pred_en_i, pred_cr_i,
                           pred_gpr_i, rc_i, cr_last_i, remap_i};
    assign need_trap_o = 1'b1;
  end else if (LEVEL == LVL_ULTRA) begin : g_ultra
    logic unused_flds;
    assign unused_flds = ^{ew_src_i, ew_dst_i, pred_en_i, pred_cr_i,
                           pred_gpr_i, rc_i, cr_last_i, remap_i};
    assign need_trap_o = ~ident_i;
  end else begin : g_full
    localparam bit HAS_WIDE = (LEVEL >= LVL_DSP);  // elwidth, CR preds, 128 CRs
    localparam bit HAS_IDX  = (LEVEL >= LVL_HDSP);
    localparam bit HAS_MTX  = (LEVEL >= LVL_ADV);
    logic gpr_ok, ew_bad, pred_bad, cr_bad, remap_bad;
    assign gpr_ok   = (pred_gpr_i == GPR_W'(3)) || (pred_gpr_i == GPR_W'(10)) ||
                      (pred_gpr_i == GPR_W'(30));
    assign ew_bad   = ((ew_src_i != 2'd0) || (ew_dst_i != 2'd0)) && !HAS_WIDE;
    assign pred_bad = pred_en_i && (pred_cr_i ? !HAS_WIDE : !gpr_ok);
    assign cr_bad   = rc_i && (cr_last_i >= CR_W'(8)) && !HAS_WIDE;
    always_comb begin
      unique case (remap_e'(remap_i))
        RMP_NONE: remap_bad = 1'b0;
        RMP_IDX:  remap_bad = !HAS_IDX;
        RMP_MTX:  remap_bad = !HAS_MTX;
        default:  remap_bad = 1'b1;
      endcase
    end
    assign need_trap_o = !ident_i && (ew_bad || pred_bad || cr_bad || remap_bad);
  end
endmodule

// File: rtl/vpfx_save.sv
module vpfx_save
  import vpfx_pkg::*;
#(
  parameter int unsigned PC_W  = 64,
  parameter int unsigned MSR_W = 64,
  parameter int unsigned VS_W  = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             exec_d_i,
  input  logic             trap_d_i,
  input  logic [PC_W-1:0]  pc_i,
  input  logic [MSR_W-1:0] msr_i,
  input  logic [VS_W-1:0]  vstate_i,
  input  logic             rfi_i,
  output logic             exec_o,
  output logic             trap_o,
  output logic [11:0]      trap_vec_o,
  output logic [PC_W-1:0]  srr_pc_o,
  output logic [MSR_W-1:0] srr_msr_o,
  output logic [VS_W-1:0]  srr_vs_o,
  output logic             vs_restore_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exec_o       <= 1'b0;
      trap_o       <= 1'b0;
      trap_vec_o   <= '0;
      vs_restore_o <= 1'b0;
    end else begin
      exec_o       <= exec_d_i;
      trap_o       <= trap_d_i;
      trap_vec_o   <= trap_d_i ? TRAP_VEC : 12'h000;
      vs_restore_o <= rfi_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      srr_pc_o  <= '0;
      srr_msr_o <= '0;
      srr_vs_o  <= '0;
    end else if (trap_d_i) begin
      srr_pc_o  <= pc_i;
      srr_msr_o <= msr_i;
      srr_vs_o  <= vstate_i;
    end
  end
endmodule

// File: rtl/vpfx_trap_chk.sv
module vpfx_trap_chk
  import vpfx_pkg::*;
#(
  parameter logic [2:0]  LEVEL = 3'd5,
  parameter int unsigned VL_W  = 7,
  parameter int unsigned CR_W  = 7,
  parameter int unsigned GPR_W = 5,
  parameter int unsigned NVS   = 4,
  parameter int unsigned PC_W  = 64,
  parameter int unsigned MSR_W = 64,
  parameter int unsigned VS_W  = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             pfx_i,
  input  logic [23:0]      mode_i,
  input  logic [VL_W-1:0]  vl_i,
  input  logic [VL_W-1:0]  maxvl_i,
  input  logic [1:0]       ew_src_i,
  input  logic [1:0]       ew_dst_i,
  input  logic             pred_en_i,
  input  logic             pred_cr_i,
  input  logic [GPR_W-1:0] pred_gpr_i,
  input  logic             pred_sz_i,
  input  logic             pred_dz_i,
  input  logic             rc_i,
  input  logic [CR_W-1:0]  cr_last_i,
  input  logic [1:0]       remap_i,
  input  logic [NVS-1:0]   vs_nz_i,
  input  logic [PC_W-1:0]  pc_i,
  input  logic [MSR_W-1:0] msr_i,
  input  logic [VS_W-1:0]  vstate_i,
  input  logic             rfi_i,
  output logic             exec_o,
  output logic             trap_o,
  output logic [11:0]      trap_vec_o,
  output logic [PC_W-1:0]  srr_pc_o,
  output logic [MSR_W-1:0] srr_msr_o,
  output logic [VS_W-1:0]  srr_vs_o,
  output logic             vs_restore_o,
  output logic [VS_W-1:0]  vs_restore_val_o
);
  localparam logic [2:0] LVL_EFF = (LEVEL > LVL_ADV) ? LVL_ADV : LEVEL;

  logic ident, need_trap, trap_d, exec_d;
  logic unused_zeroing;  // sz/dz accepted at every level
  assign unused_zeroing = pred_sz_i ^ pred_dz_i;

  vpfx_ident #(.VL_W(VL_W), .NVS(NVS)) i_ident (
    .mode_i  (mode_i),
    .vl_i    (vl_i),
    .maxvl_i (maxvl_i),
    .vs_nz_i (vs_nz_i),
    .ident_o (ident)
  );

  vpfx_rules #(.LEVEL(LVL_EFF), .CR_W(CR_W), .GPR_W(GPR_W)) i_rules (
    .ident_i     (ident),
    .ew_src_i    (ew_src_i),
    .ew_dst_i    (ew_dst_i),
    .pred_en_i   (pred_en_i),
    .pred_cr_i   (pred_cr_i),
    .pred_gpr_i  (pred_gpr_i),
    .rc_i        (rc_i),
    .cr_last_i   (cr_last_i),
    .remap_i     (remap_i),
    .need_trap_o (need_trap)
  );

  assign trap_d = valid_i && pfx_i && need_trap;
  assign exec_d = valid_i && !(pfx_i && need_trap);

  vpfx_save #(.PC_W(PC_W), .MSR_W(MSR_W), .VS_W(VS_W)) i_save (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .exec_d_i     (exec_d),
    .trap_d_i     (trap_d),
    .pc_i         (pc_i),
    .msr_i        (msr_i),
    .vstate_i     (vstate_i),
    .rfi_i        (rfi_i),
    .exec_o       (exec_o),
    .trap_o       (trap_o),
    .trap_vec_o   (trap_vec_o),
    .srr_pc_o     (srr_pc_o),
    .srr_msr_o    (srr_msr_o),
    .srr_vs_o     (srr_vs_o),
    .vs_restore_o (vs_restore_o)
  );

  assign vs_restore_val_o = srr_vs_o;
endmodule

// File: rtl/vpfx_trap_chk_sva.sv
module vpfx_trap_chk_sva #(
  parameter logic [2:0]  LEVEL = 3'd5,
  parameter int unsigned VL_W  = 7,
  parameter int unsigned CR_W  = 7,
  parameter int unsigned NVS   = 4,
  parameter int unsigned PC_W  = 64,
  parameter int unsigned VS_W  = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            valid_i,
  input logic            pfx_i,
  input logic [23:0]     mode_i,
  input logic [VL_W-1:0] vl_i,
  input logic [VL_W-1:0] maxvl_i,
  input logic [1:0]      ew_src_i,
  input logic [1:0]      ew_dst_i,
  input logic            rc_i,
  input logic [CR_W-1:0] cr_last_i,
  input logic [NVS-1:0]  vs_nz_i,
  input logic [PC_W-1:0] pc_i,
  input logic [VS_W-1:0] vstate_i,
  input logic            rfi_i,
  input logic            exec_o,
  input logic            trap_o,
  input logic [11:0]     trap_vec_o,
  input logic [PC_W-1:0] srr_pc_o,
  input logic [VS_W-1:0] srr_vs_o,
  input logic            vs_restore_o
);
  p_unpfx_exec_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !pfx_i |=> exec_o && !trap_o);

  p_lvl0_trap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (LEVEL == 3'd0) && valid_i && pfx_i |=> trap_o);

  p_ident_exec_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (LEVEL != 3'd0) && valid_i && pfx_i && (mode_i == 24'd0) && (vs_nz_i == '0) &&
    (vl_i <= VL_W'(1)) && (maxvl_i <= VL_W'(1)) |=> exec_o);

  p_lvl1_trap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (LEVEL == 3'd1) && valid_i && pfx_i && (mode_i != 24'd0) |=> trap_o);

  p_ew_trap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (LEVEL < 3'd3) && valid_i && pfx_i && (mode_i != 24'd0) &&
    ((ew_src_i != 2'd0) || (ew_dst_i != 2'd0)) |=> trap_o);

  p_cr_trap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (LEVEL < 3'd3) && valid_i && pfx_i && (mode_i != 24'd0) && rc_i &&
    (cr_last_i >= CR_W'(8)) |=> trap_o);

  p_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !exec_o && !trap_o);

  p_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(exec_o && trap_o));

  p_vec_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> (trap_vec_o == 12'h700));

  p_novec_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trap_o |-> (trap_vec_o == 12'h000));

  p_save_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> (srr_pc_o == $past(pc_i)) && (srr_vs_o == $past(vstate_i)));

  p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trap_o |-> $stable(srr_vs_o));

  p_restore_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rfi_i |=> vs_restore_o);
endmodule

bind vpfx_trap_chk vpfx_trap_chk_sva #(
  .LEVEL(LVL_EFF), .VL_W(VL_W), .CR_W(CR_W), .NVS(NVS), .PC_W(PC_W), .VS_W(VS_W)
) i_sva (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .pfx_i(pfx_i),
  .mode_i(mode_i), .vl_i(vl_i), .maxvl_i(maxvl_i), .ew_src_i(ew_src_i),
  .ew_dst_i(ew_dst_i), .rc_i(rc_i), .cr_last_i(cr_last_i), .vs_nz_i(vs_nz_i),
  .pc_i(pc_i), .vstate_i(vstate_i), .rfi_i(rfi_i), .exec_o(exec_o),
  .trap_o(trap_o), .trap_vec_o(trap_vec_o), .srr_pc_o(srr_pc_o),
  .srr_vs_o(srr_vs_o), .vs_restore_o(vs_restore_o)
);

// File: tb/test_vpfx_trap_chk.sv
`timescale 1ns/1ps
module test_vpfx_trap_chk;
  localparam int NL = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        valid, pfx, pred_en, pred_cr, pred_sz, pred_dz, rc, rfi;
  logic [23:0] mode;
  logic [6:0]  vl, maxvl, cr_last;
  logic [1:0]  ew_src, ew_dst, remap;
  logic [4:0]  pred_gpr;
  logic [3:0]  vs_nz;
  logic [63:0] pc, msr;
  logic [31:0] vstate;

  logic        exec_w [NL];
  logic        trap_w [NL];
  logic [11:0] vec_w  [NL];
  logic [63:0] spc_w  [NL];
  logic [63:0] smsr_w [NL];
  logic [31:0] svs_w  [NL];
  logic        rst_w  [NL];
  logic [31:0] rval_w [NL];

  for (genvar l = 0; l < NL; l++) begin : g_lvl
    vpfx_trap_chk #(.LEVEL(3'(l))) i_vpfx_trap_chk (
      .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .pfx_i(pfx), .mode_i(mode),
      .vl_i(vl), .maxvl_i(maxvl), .ew_src_i(ew_src), .ew_dst_i(ew_dst),
      .pred_en_i(pred_en), .pred_cr_i(pred_cr), .pred_gpr_i(pred_gpr),
      .pred_sz_i(pred_sz), .pred_dz_i(pred_dz), .rc_i(rc), .cr_last_i(cr_last),
      .remap_i(remap), .vs_nz_i(vs_nz), .pc_i(pc), .msr_i(msr), .vstate_i(vstate),
      .rfi_i(rfi), .exec_o(exec_w[l]), .trap_o(trap_w[l]), .trap_vec_o(vec_w[l]),
      .srr_pc_o(spc_w[l]), .srr_msr_o(smsr_w[l]), .srr_vs_o(svs_w[l]),
      .vs_restore_o(rst_w[l]), .vs_restore_val_o(rval_w[l])
    );
  end

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_in();
    valid = 0; pfx = 0; mode = 0; vl = 1; maxvl = 1; ew_src = 0; ew_dst = 0;
    pred_en = 0; pred_cr = 0; pred_gpr = 0; pred_sz = 0; pred_dz = 0;
    rc = 0; cr_last = 0; remap = 0; vs_nz = 0; pc = 0; msr = 0; vstate = 0; rfi = 0;
  endtask

  // one-cycle valid, check at the next falling edge; mask bit l = level l traps
  task automatic issue(string tag, logic [NL-1:0] mask);
    valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
    for (int l = 0; l < NL; l++) begin
      chk($sformatf("%s trap L%0d", tag, l), 64'(trap_w[l]), 64'(mask[l]));
      chk($sformatf("%s exec L%0d", tag, l), 64'(exec_w[l]), 64'(!mask[l]));
      chk($sformatf("%s vec L%0d", tag, l), 64'(vec_w[l]), mask[l] ? 64'h700 : 64'h0);
    end
    clear_in();
  endtask

  task automatic t_reset();
    for (int l = 0; l < NL; l++) begin
      chk("R10 reset exec", 64'(exec_w[l]), 0);
      chk("R10 reset trap", 64'(trap_w[l]), 0);
      chk("R11 reset srr_pc", spc_w[l], 0);
      chk("R11 reset srr_vs", 64'(svs_w[l]), 0);
    end
  endtask

  task automatic t_unpfx();
    mode = 24'hFFFFFF; vl = 4; maxvl = 4; ew_src = 2; rc = 1; cr_last = 20;
    remap = 3; pred_en = 1; pred_gpr = 5; vs_nz = 4'hF;
    issue("R1 unprefixed", 6'b000000);
  endtask

  task automatic t_ident();
    pfx = 1;
    issue("R2 R3 identity", 6'b000001);
    pfx = 1; vs_nz = 4'b0100;
    issue("R3 R4 vs nonzero", 6'b000011);
    pfx = 1; vl = 4; maxvl = 4;
    issue("R3 R4 vl4 mode0", 6'b000011);
  endtask

  task automatic t_vloop();
    pfx = 1; mode = 24'h1; vl = 4; maxvl = 4; vs_nz = 4'b0001;
    issue("R4 R5 vl4", 6'b000011);
  endtask

  task automatic t_ew();
    pfx = 1; mode = 24'h1; ew_dst = 1;
    issue("R6 ew dst", 6'b000111);
    pfx = 1; mode = 24'h1; ew_src = 3;
    issue("R6 ew src", 6'b000111);
  endtask

  task automatic t_pred();
    pfx = 1; mode = 24'h2; pred_en = 1; pred_gpr = 10; pred_sz = 1; pred_dz = 1;
    issue("R7 pred r10 sz dz", 6'b000011);
    pfx = 1; mode = 24'h2; pred_en = 1; pred_gpr = 30;
    issue("R7 pred r30", 6'b000011);
    pfx = 1; mode = 24'h2; pred_en = 1; pred_gpr = 5;
    issue("R7 pred r5", 6'b111111);
    pfx = 1; mode = 24'h2; pred_en = 1; pred_cr = 1;
    issue("R7 pred cr", 6'b000111);
  endtask

  task automatic t_rc();
    pfx = 1; mode = 24'h4; vl = 8; maxvl = 8; rc = 1; cr_last = 7;
    issue("R8 cr7", 6'b000011);
    pfx = 1; mode = 24'h4; vl = 9; maxvl = 9; rc = 1; cr_last = 8;
    issue("R8 cr8", 6'b000111);
    pfx = 1; mode = 24'h4; rc = 0; cr_last = 100;
    issue("R8 rc0 cr100", 6'b000011);
  endtask

  task automatic t_remap();
    pfx = 1; mode = 24'h8; remap = 1;
    issue("R9 remap idx", 6'b001111);
    pfx = 1; mode = 24'h8; remap = 2;
    issue("R9 remap mtx", 6'b011111);
    pfx = 1; mode = 24'h8; remap = 3;
    issue("R9 remap rsvd", 6'b111111);
  endtask

  task automatic t_multi();
    pfx = 1; mode = 24'h10; ew_src = 1; rc = 1; cr_last = 50; remap = 1;
    issue("R10 multi", 6'b001111);
  endtask

  task automatic t_idle();
    pfx = 1; mode = 24'h1; remap = 3;
    @(negedge clk);
    for (int l = 0; l < NL; l++) begin
      chk("R10 idle exec", 64'(exec_w[l]), 0);
      chk("R10 idle trap", 64'(trap_w[l]), 0);
    end
    clear_in();
  endtask

  task automatic t_save();
    pfx = 1; pc = 64'h1234; msr = 64'h8000; vstate = 32'hCAFE;
    issue("R11 save issue", 6'b000001);
    chk("R11 srr_pc", spc_w[0], 64'h1234);
    chk("R11 srr_msr", smsr_w[0], 64'h8000);
    chk("R11 srr_vs", 64'(svs_w[0]), 64'hCAFE);
    chk("R11 no save L1", 64'(svs_w[1]), 0);
    pc = 64'h5555; msr = 64'h1; vstate = 32'hBEEF;
    issue("R11 hold issue", 6'b000000);
    chk("R11 hold pc", spc_w[0], 64'h1234);
    chk("R11 hold vs", 64'(svs_w[0]), 64'hCAFE);
    rfi = 1;
    @(negedge clk);
    rfi = 0;
    chk("R12 restore pulse", 64'(rst_w[0]), 1);
    chk("R12 restore val", 64'(rval_w[0]), 64'hCAFE);
    @(negedge clk);
    chk("R12 restore ends", 64'(rst_w[0]), 0);
    chk("R11 hold after rfi", 64'(svs_w[0]), 64'hCAFE);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    clear_in();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_unpfx();
    t_ident();
    t_vloop();
    t_ew();
    t_pred();
    t_rc();
    t_remap();
    t_multi();
    t_idle();
    t_save();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule